// File: doc/BRIEF.md
# Oldest-First Instruction Issue Queue

This block holds instructions that have been dispatched but have not yet finished, and hands them one per cycle to an execution port in age order. Every instruction carries an index that grows by one per dispatch and wraps around; a smaller index, in modular terms, means an older instruction. Each held instruction is in one of three states. It is waiting while its operands or memory dependencies are still pending. It is ready once they are all satisfied. It is executing after issue, until its write-back notice arrives.

A dispatcher presents an instruction together with a flag saying whether its operands are already available. A dependency-tracking unit broadcasts the index of a waiting instruction once everything it needs is resolved. The execution side offers a resource-available strobe each cycle and later reports completion by index. An instruction marked zero-latency may skip the queue entirely: if the issue port is idle in the cycle it is dispatched, it issues at once and never takes a slot.

Top module: `oldest_issue_queue`

## Requirements
- R1: Out of synchronous active-low reset, every slot is free, `disp_full` is 0 and `issue_valid` is 0.
- R2: An accepted dispatch with `disp_ops_ready`=1 that does not take the bypass enters the ready state at the clock edge and can issue from the next cycle. An index presented at dispatch must not match any index the queue already holds.
- R3: An accepted dispatch with `disp_ops_ready`=0 enters the waiting state. A wakeup carrying its index promotes it to ready at the edge. It can issue in the cycle after the wakeup, because promotion comes before selection in that cycle.
- R4: When several entries are ready, the issued one is the oldest. Age is decided by modular index difference: a is older than b when the top bit of (a-b) mod 2^IDXW is 1. The held indices must span fewer than 2^(IDXW-1) values.
- R5: At most one instruction issues per cycle, and only while `res_avail`=1. An issued entry becomes executing at the edge and is never offered again.
- R6: A write-back whose index matches an executing entry frees that slot at the edge.
- R7: `disp_full` is 1 exactly when all DEPTH slots are held. A dispatch presented while full is discarded.
- R8: A zero-latency dispatch with its operands ready issues in the same cycle, with `issue_bypass`=1 and `issue_idx`=`disp_idx`, when `res_avail`=1, the queue is not full and no held entry is ready. It occupies no slot.
- R9: A zero-latency dispatch that cannot take the bypass because a ready entry holds the port or `res_avail`=0 is queued like any other dispatch: it goes to ready if its operands are available, and to waiting otherwise.
- R10: A wakeup whose index does not match a waiting entry, and a write-back whose index does not match an executing entry, change nothing.
- R11: In a cycle with no issue, `issue_idx` is 0 and `issue_bypass` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_idx | input | IDXW | Index of the dispatched instruction |
| disp_ops_ready | input | 1 | All operands and memory dependencies already satisfied |
| disp_zero_lat | input | 1 | Instruction is zero-latency and may take the bypass |
| disp_full | output | 1 | No free slot; dispatch is discarded |
| wake_valid | input | 1 | Dependency-resolved broadcast this cycle |
| wake_idx | input | IDXW | Index of the instruction whose dependencies resolved |
| res_avail | input | 1 | Execution resources can accept an instruction this cycle |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_idx | output | IDXW | Index of the issued instruction, 0 when idle |
| issue_bypass | output | 1 | Issued instruction came straight from dispatch |
| wb_valid | input | 1 | Write-back notice this cycle |
| wb_idx | input | IDXW | Index of the instruction that reached write-back |

## Verification
The bench builds the queue with DEPTH=4 and IDXW=4. With so few slots the full condition, dispatches refused while full and competition for the single issue port come up within a few cycles of any sequence. With only sixteen index values, the age comparison across the wrap from 15 to 0 is reached by directed stimulus and also, many times over, by the long mixed sweep that follows. The sweep draws dispatch, wakeup, resource and write-back activity each cycle. Its wakeups and write-backs sometimes target live entries and sometimes stray indices, so the ignore rules come up together with the normal promotions and frees.

// File: rtl/iq_pkg.sv
`timescale 1ns/1ps
// Shared types for the issue queue.
package iq_pkg;
    // Lifecycle of one queue slot: empty, waiting on dependencies,
    // eligible for issue, or issued and awaiting write-back.
    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2,
        ST_EXEC  = 2'd3
    } slot_state_e;
endpackage

// File: rtl/iq_slot.sv
`timescale 1ns/1ps
// One issue-queue slot.
// Holds one instruction index and its lifecycle state.
// Assumes: alloc is raised only while the slot is free; grant only while ready.
module iq_slot
    import iq_pkg::*;
#(
    parameter int IDXW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [IDXW-1:0]   alloc_idx,
    input  logic              alloc_ready,
    input  logic              wake_valid,
    input  logic [IDXW-1:0]   wake_idx,
    input  logic              grant,
    input  logic              wb_valid,
    input  logic [IDXW-1:0]   wb_idx,
    output slot_state_e       state,
    output logic [IDXW-1:0]   idx
);

    logic wake_hit;
    logic wb_hit;

    // Match the broadcast indices against the held index.
    always_comb begin
        wake_hit = wake_valid && (state == ST_WAIT) && (wake_idx == idx);
        wb_hit   = wb_valid && (state == ST_EXEC) && (wb_idx == idx);
    end

    // Advance the slot through free, wait, ready and executing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FREE;
            idx   <= '0;
        end else if (alloc) begin
            state <= alloc_ready ? ST_READY : ST_WAIT;
            idx   <= alloc_idx;
        end else if (wake_hit) begin
            state <= ST_READY;
        end else if (grant && state == ST_READY) begin
            state <= ST_EXEC;
        end else if (wb_hit) begin
            state <= ST_FREE;
        end
    end

endmodule

// File: rtl/iq_alloc.sv
`timescale 1ns/1ps
// Free-slot finder.
// Picks the lowest-numbered free slot as a one-hot vector and reports
// when no slot is free. Assumes nothing about the order of slot use.
module iq_alloc #(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0] free_vec,
    output logic [DEPTH-1:0] alloc_oh,
    output logic             full
);

    // Isolate the lowest set bit of the free vector.
    always_comb begin
        alloc_oh = free_vec & (~free_vec + DEPTH'(1));
        full     = ~|free_vec;
    end

endmodule

// File: rtl/iq_age_pick.sv
`timescale 1ns/1ps
// Oldest-first selector.
// Among the flagged slots, finds the one whose index is oldest under
// modular comparison. Assumes the live indices span under half the range.
module iq_age_pick #(
    parameter int DEPTH = 8,
    parameter int IDXW  = 6
) (
    input  logic [DEPTH-1:0] cand,
    input  logic [IDXW-1:0]  idx [DEPTH],
    output logic             any,
    output logic [DEPTH-1:0] pick_oh,
    output logic [IDXW-1:0]  pick_idx
);

    localparam int SELW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    // True when a is older than b under wrap-around ordering.
    function automatic logic is_older(input logic [IDXW-1:0] a,
                                      input logic [IDXW-1:0] b);
        logic [IDXW-1:0] diff;
        diff = a - b;
        return diff[IDXW-1];
    endfunction

    logic [SELW-1:0] best;

    // Linear scan keeping the oldest candidate seen so far.
    always_comb begin
        any  = 1'b0;
        best = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cand[i] && (!any || is_older(idx[i], idx[best]))) begin
                best = SELW'(i);
                any  = 1'b1;
            end
        end
        pick_oh  = any ? (DEPTH'(1) << best) : '0;
        pick_idx = any ? idx[best] : '0;
    end

endmodule

// File: rtl/oldest_issue_queue.sv
`timescale 1ns/1ps
// Oldest-first issue queue.
// Holds dispatched instructions in waiting, ready and executing states,
// issues the oldest ready one per cycle while resources are available,
// and lets a zero-latency instruction bypass the queue when the port is
// idle. Assumes unique live indices spanning under 2^(IDXW-1) values.
module oldest_issue_queue
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDXW  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            disp_valid,
    input  logic [IDXW-1:0] disp_idx,
    input  logic            disp_ops_ready,
    input  logic            disp_zero_lat,
    output logic            disp_full,
    input  logic            wake_valid,
    input  logic [IDXW-1:0] wake_idx,
    input  logic            res_avail,
    output logic            issue_valid,
    output logic [IDXW-1:0] issue_idx,
    output logic            issue_bypass,
    input  logic            wb_valid,
    input  logic [IDXW-1:0] wb_idx
);

    slot_state_e      slot_st  [DEPTH];
    logic [IDXW-1:0]  slot_idx [DEPTH];
    logic [DEPTH-1:0] free_vec;
    logic [DEPTH-1:0] ready_vec;
    logic [DEPTH-1:0] alloc_oh;
    logic [DEPTH-1:0] pick_oh;
    logic             pick_any;
    logic [IDXW-1:0]  pick_idx;
    logic             accept;
    logic             q_issue;
    logic             bypass;
    logic             alloc_go;

    // Gather per-slot state into free and ready vectors.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            free_vec[i]  = (slot_st[i] == ST_FREE);
            ready_vec[i] = (slot_st[i] == ST_READY);
        end
    end

    iq_alloc #(.DEPTH(DEPTH)) u_alloc (
        .free_vec (free_vec),
        .alloc_oh (alloc_oh),
        .full     (disp_full)
    );

    iq_age_pick #(.DEPTH(DEPTH), .IDXW(IDXW)) u_pick (
        .cand     (ready_vec),
        .idx      (slot_idx),
        .any      (pick_any),
        .pick_oh  (pick_oh),
        .pick_idx (pick_idx)
    );

    // Decide between queue issue, bypass issue and slot allocation.
    always_comb begin
        accept       = disp_valid && !disp_full;
        q_issue      = res_avail && pick_any;
        bypass       = res_avail && !pick_any && accept
                       && disp_zero_lat && disp_ops_ready;
        alloc_go     = accept && !bypass;
        issue_valid  = q_issue || bypass;
        issue_bypass = bypass;
        issue_idx    = q_issue ? pick_idx : (bypass ? disp_idx : '0);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        iq_slot #(.IDXW(IDXW)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc       (alloc_go && alloc_oh[g]),
            .alloc_idx   (disp_idx),
            .alloc_ready (disp_ops_ready),
            .wake_valid  (wake_valid),
            .wake_idx    (wake_idx),
            .grant       (q_issue && pick_oh[g]),
            .wb_valid    (wb_valid),
            .wb_idx      (wb_idx),
            .state       (slot_st[g]),
            .idx         (slot_idx[g])
        );
    end

endmodule

// File: rtl/iq_checker.sv
`timescale 1ns/1ps
// Property checker for the issue queue, bound to every instance.
// Observes the ports and the slot array; drives nothing.
module iq_checker
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDXW  = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            disp_valid,
    input logic [IDXW-1:0] disp_idx,
    input logic            disp_full,
    input logic            res_avail,
    input logic            issue_valid,
    input logic [IDXW-1:0] issue_idx,
    input logic            issue_bypass,
    input logic            wb_valid,
    input logic [IDXW-1:0] wb_idx,
    input slot_state_e     slot_st  [DEPTH],
    input logic [IDXW-1:0] slot_idx [DEPTH]
);

    logic            dup_hit;
    logic            older_ready;
    logic            any_ready;
    logic            all_held;
    logic            wb_hit;
    logic            wb_idx_live;
    logic            iss_idx_exec;
    logic [IDXW-1:0] wb_idx_q;
    logic [IDXW-1:0] iss_idx_q;
    logic [IDXW-1:0] age_gap;

    // Register the indices the next-cycle properties refer to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_idx_q  <= '0;
            iss_idx_q <= '0;
        end else begin
            wb_idx_q  <= wb_idx;
            iss_idx_q <= issue_idx;
        end
    end

    // Scan the slot array for the facts the properties need.
    always_comb begin
        dup_hit      = 1'b0;
        older_ready  = 1'b0;
        any_ready    = 1'b0;
        all_held     = 1'b1;
        wb_hit       = 1'b0;
        wb_idx_live  = 1'b0;
        iss_idx_exec = 1'b0;
        age_gap      = '0;
        for (int i = 0; i < DEPTH; i++) begin
            age_gap = slot_idx[i] - issue_idx;
            if (slot_st[i] == ST_FREE) all_held = 1'b0;
            if (slot_st[i] != ST_FREE && slot_idx[i] == disp_idx) dup_hit = 1'b1;
            if (slot_st[i] == ST_READY) any_ready = 1'b1;
            if (slot_st[i] == ST_READY && age_gap[IDXW-1]) older_ready = 1'b1;
            if (slot_st[i] == ST_EXEC && slot_idx[i] == wb_idx) wb_hit = 1'b1;
            if (slot_st[i] != ST_FREE && slot_idx[i] == wb_idx_q) wb_idx_live = 1'b1;
            if (slot_st[i] == ST_EXEC && slot_idx[i] == iss_idx_q) iss_idx_exec = 1'b1;
        end
    end

    // R2: a dispatched index must not already be held.
    assert_no_dup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_full) |-> !dup_hit);

    // R4: no ready entry is older than the one issued from the queue.
    assert_oldest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !issue_bypass) |-> !older_ready);

    // R5: issue only with resources available.
    assert_needs_res_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> res_avail);

    // R5: a queue issue leaves its entry executing.
    assert_exec_after_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !issue_bypass) |=> iss_idx_exec);

    // R6: a matching write-back removes the entry.
    assert_wb_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_hit) |=> !wb_idx_live);

    // R7: full flag agrees with slot occupancy.
    assert_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_full == all_held);

    // R8: bypass only when no queued entry is ready.
    assert_bypass_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        issue_bypass |-> (!any_ready && issue_valid));

endmodule

bind oldest_issue_queue iq_checker #(.DEPTH(DEPTH), .IDXW(IDXW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .disp_valid   (disp_valid),
    .disp_idx     (disp_idx),
    .disp_full    (disp_full),
    .res_avail    (res_avail),
    .issue_valid  (issue_valid),
    .issue_idx    (issue_idx),
    .issue_bypass (issue_bypass),
    .wb_valid     (wb_valid),
    .wb_idx       (wb_idx),
    .slot_st      (slot_st),
    .slot_idx     (slot_idx)
);

// File: tb/tb_oldest_issue_queue.sv
`timescale 1ns/1ps
// Bench: directed cases plus a long mixed sweep against a behavioural model.
module tb_oldest_issue_queue;

    localparam int DEPTH = 4;
    localparam int IDXW  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            disp_valid = 1'b0;
    logic [IDXW-1:0] disp_idx = '0;
    logic            disp_ops_ready = 1'b0;
    logic            disp_zero_lat = 1'b0;
    logic            disp_full;
    logic            wake_valid = 1'b0;
    logic [IDXW-1:0] wake_idx = '0;
    logic            res_avail = 1'b0;
    logic            issue_valid;
    logic [IDXW-1:0] issue_idx;
    logic            issue_bypass;
    logic            wb_valid = 1'b0;
    logic [IDXW-1:0] wb_idx = '0;

    int total = 0;
    int fails = 0;

    // Model: 0 free, 1 waiting, 2 ready, 3 executing.
    int              m_st  [DEPTH];
    logic [IDXW-1:0] m_idx [DEPTH];

    logic            a_full, a_iv, a_byp;
    logic [IDXW-1:0] a_ii;

    always #2 clk = ~clk;

    oldest_issue_queue #(.DEPTH(DEPTH), .IDXW(IDXW)) dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_idx(disp_idx),
        .disp_ops_ready(disp_ops_ready), .disp_zero_lat(disp_zero_lat),
        .disp_full(disp_full),
        .wake_valid(wake_valid), .wake_idx(wake_idx),
        .res_avail(res_avail),
        .issue_valid(issue_valid), .issue_idx(issue_idx), .issue_bypass(issue_bypass),
        .wb_valid(wb_valid), .wb_idx(wb_idx)
    );

    function automatic logic older(input logic [IDXW-1:0] a, input logic [IDXW-1:0] b);
        logic [IDXW-1:0] d;
        d = a - b;
        return d[IDXW-1];
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(input logic dv, input logic [IDXW-1:0] di, input logic dops,
                        input logic dzl, input logic wv, input logic [IDXW-1:0] wi,
                        input logic res, input logic wbv, input logic [IDXW-1:0] wbi);
        int cnt, pk, fr;
        logic has, e_full, acc, e_iv, e_byp;
        logic [IDXW-1:0] e_ii;
        int old_st [DEPTH];
        @(negedge clk);
        disp_valid = dv; disp_idx = di; disp_ops_ready = dops; disp_zero_lat = dzl;
        wake_valid = wv; wake_idx = wi; res_avail = res; wb_valid = wbv; wb_idx = wbi;
        #1;
        cnt = 0; has = 1'b0; pk = 0;
        for (int k = 0; k < DEPTH; k++) begin
            if (m_st[k] != 0) cnt++;
            if (m_st[k] == 2 && (!has || older(m_idx[k], m_idx[pk]))) begin
                pk = k; has = 1'b1;
            end
        end
        e_full = (cnt == DEPTH);
        acc    = dv && !e_full;
        e_byp  = res && !has && acc && dzl && dops;
        e_iv   = (res && has) || e_byp;
        e_ii   = (res && has) ? m_idx[pk] : (e_byp ? di : '0);
        a_full = disp_full; a_iv = issue_valid; a_ii = issue_idx; a_byp = issue_bypass;
        chk(a_full == e_full, "R7 full flag", a_full, e_full);
        chk(a_iv == e_iv, "R5 issue valid", a_iv, e_iv);
        chk(a_ii == e_ii, "R4 issue index", a_ii, e_ii);
        chk(a_byp == e_byp, "R8 bypass flag", a_byp, e_byp);
        @(posedge clk);
        for (int k = 0; k < DEPTH; k++) old_st[k] = m_st[k];
        if (res && has) m_st[pk] = 3;
        for (int k = 0; k < DEPTH; k++) begin
            if (wv && old_st[k] == 1 && m_idx[k] == wi) m_st[k] = 2;
            if (wbv && old_st[k] == 3 && m_idx[k] == wbi) m_st[k] = 0;
        end
        if (acc && !e_byp) begin
            fr = -1;
            for (int k = 0; k < DEPTH; k++) if (fr < 0 && old_st[k] == 0) fr = k;
            m_st[fr]  = dops ? 2 : 1;
            m_idx[fr] = di;
        end
    endtask

    task automatic disp(input logic [IDXW-1:0] di, input logic dops, input logic dzl,
                        input logic res);
        step(1'b1, di, dops, dzl, 1'b0, '0, res, 1'b0, '0);
    endtask

    task automatic wake(input logic [IDXW-1:0] wi, input logic res);
        step(1'b0, '0, 1'b0, 1'b0, 1'b1, wi, res, 1'b0, '0);
    endtask

    task automatic wb(input logic [IDXW-1:0] wbi, input logic res);
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, res, 1'b1, wbi);
    endtask

    task automatic idle(input logic res);
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, res, 1'b0, '0);
    endtask

    task automatic expect_issue(input string tag, input logic iv, input logic [IDXW-1:0] ii,
                                input logic byp);
        chk(a_iv == iv, tag, a_iv, iv);
        chk(a_ii == ii, tag, a_ii, ii);
        chk(a_byp == byp, tag, a_byp, byp);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        #400000;
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [IDXW-1:0] nxt, oldest, wi, wbi, gap;
        logic dv, has_live, dops, dzl, wv, res, wbv;
        int cnt;
        logic [31:0] r;

        for (int k = 0; k < DEPTH; k++) begin m_st[k] = 0; m_idx[k] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(disp_full == 1'b0, "R1 full after reset", disp_full, 0);
        chk(issue_valid == 1'b0, "R1 no issue after reset", issue_valid, 0);
        rst_n = 1'b1;

        // R2 R4 R5: three ready entries held back, then released in age order.
        disp(4'd0, 1'b1, 1'b0, 1'b0);
        disp(4'd1, 1'b1, 1'b0, 1'b0);
        disp(4'd2, 1'b1, 1'b0, 1'b0);
        expect_issue("R5 no issue while res_avail low", 1'b0, 4'd0, 1'b0);
        idle(1'b1); expect_issue("R2 ready entry issues", 1'b1, 4'd0, 1'b0);
        idle(1'b1); expect_issue("R4 next oldest", 1'b1, 4'd1, 1'b0);
        idle(1'b1); expect_issue("R4 youngest last", 1'b1, 4'd2, 1'b0);
        idle(1'b1); expect_issue("R5 executing not reissued", 1'b0, 4'd0, 1'b0);
        expect_issue("R11 idle outputs zero", 1'b0, 4'd0, 1'b0);
        wb(4'd0, 1'b1); wb(4'd1, 1'b1); wb(4'd2, 1'b1);

        // R3: waiting entry promoted by wakeup.
        disp(4'd3, 1'b0, 1'b0, 1'b1);
        idle(1'b1); expect_issue("R3 waiting entry held", 1'b0, 4'd0, 1'b0);
        wake(4'd3, 1'b1); expect_issue("R3 no issue in wakeup cycle", 1'b0, 4'd0, 1'b0);
        idle(1'b1); expect_issue("R3 issues after promotion", 1'b1, 4'd3, 1'b0);
        wb(4'd3, 1'b1);

        // R10: stray wakeup and stray write-back change nothing.
        disp(4'd4, 1'b0, 1'b0, 1'b1);
        wake(4'd9, 1'b1);
        idle(1'b1); expect_issue("R10 stray wakeup ignored", 1'b0, 4'd0, 1'b0);
        wb(4'd4, 1'b1);
        wake(4'd4, 1'b1);
        idle(1'b1); expect_issue("R10 write-back of waiting entry ignored", 1'b1, 4'd4, 1'b0);
        wb(4'd4, 1'b1);

        // R8: bypass into an idle port.
        disp(4'd5, 1'b1, 1'b1, 1'b1); expect_issue("R8 bypass same cycle", 1'b1, 4'd5, 1'b1);
        idle(1'b1); expect_issue("R8 bypassed entry holds no slot", 1'b0, 4'd0, 1'b0);

        // R9: bypass refused while an older entry is ready.
        disp(4'd6, 1'b1, 1'b0, 1'b0);
        disp(4'd7, 1'b1, 1'b1, 1'b1); expect_issue("R9 older entry wins port", 1'b1, 4'd6, 1'b0);
        idle(1'b1); expect_issue("R9 refused bypass queued", 1'b1, 4'd7, 1'b0);
        wb(4'd6, 1'b1); wb(4'd7, 1'b1);

        // R7 R6: fill, refuse, then free one slot.
        disp(4'd8, 1'b0, 1'b0, 1'b0);
        disp(4'd9, 1'b0, 1'b0, 1'b0);
        disp(4'd10, 1'b0, 1'b0, 1'b0);
        disp(4'd11, 1'b0, 1'b0, 1'b0);
        disp(4'd12, 1'b1, 1'b0, 1'b1);
        chk(a_full == 1'b1, "R7 full with all slots held", a_full, 1);
        chk(a_iv == 1'b0, "R7 dispatch while full discarded", a_iv, 0);
        wake(4'd8, 1'b1);
        idle(1'b1); expect_issue("R7 entry issues", 1'b1, 4'd8, 1'b0);
        idle(1'b1); expect_issue("R7 refused dispatch absent", 1'b0, 4'd0, 1'b0);
        chk(a_full == 1'b1, "R7 executing entry still held", a_full, 1);
        wb(4'd8, 1'b0);
        idle(1'b0);
        chk(a_full == 1'b0, "R6 write-back frees slot", a_full, 0);
        wake(4'd9, 1'b1); wake(4'd10, 1'b1); wake(4'd11, 1'b1);
        idle(1'b1);
        wb(4'd9, 1'b0); wb(4'd10, 1'b0); wb(4'd11, 1'b0);

        // R4: age order across the index wrap, promoted youngest first.
        disp(4'd14, 1'b0, 1'b0, 1'b0);
        disp(4'd15, 1'b0, 1'b0, 1'b0);
        disp(4'd0, 1'b0, 1'b0, 1'b0);
        wake(4'd0, 1'b0); wake(4'd15, 1'b0); wake(4'd14, 1'b0);
        idle(1'b1); expect_issue("R4 wrap oldest 14", 1'b1, 4'd14, 1'b0);
        idle(1'b1); expect_issue("R4 wrap then 15", 1'b1, 4'd15, 1'b0);
        idle(1'b1); expect_issue("R4 wrap then 0", 1'b1, 4'd0, 1'b0);
        wb(4'd14, 1'b0); wb(4'd15, 1'b0); wb(4'd0, 1'b0);

        // Mixed sweep against the model.
        nxt = 4'd1;
        for (int c = 0; c < 6000; c++) begin
            r = $urandom;
            has_live = 1'b0; oldest = '0; cnt = 0;
            for (int k = 0; k < DEPTH; k++) begin
                if (m_st[k] != 0) begin
                    cnt++;
                    if (!has_live || older(m_idx[k], oldest)) oldest = m_idx[k];
                    has_live = 1'b1;
                end
            end
            gap  = nxt - oldest;
            dv   = r[0] | r[1];
            if (has_live && gap >= 4'd7) dv = 1'b0;
            dops = r[2];
            dzl  = r[3] & r[4];
            wv   = r[7];
            wi   = (m_st[r[6:5]] == 1) ? m_idx[r[6:5]] : r[15:12];
            res  = r[8] | r[9];
            wbv  = r[10];
            wbi  = (m_st[r[18:17]] == 3 && r[11]) ? m_idx[r[18:17]] : r[22:19];
            step(dv, nxt, dops, dzl, wv, wi, res, wbv, wbi);
            if (dv && cnt < DEPTH) nxt = nxt + 1'b1;
        end

        idle(1'b0);
        summary();
        $finish;
    end

endmodule